// File: doc/BRIEF.md
# FIFO Word Adapter

This block sits between a byte-oriented client and a pair of 32-bit word FIFOs that feed a serial shifter. On the transmit side it gathers one, two or four bytes into a word, the count chosen by the configured bits per word, and pushes each finished word into the output FIFO. On the receive side it pops words from the input FIFO and hands their bytes out one at a time. Both directions count bytes against a transfer length loaded by a start pulse.

The two directions place bytes differently. Transmit bytes fill the word from the most significant byte lane downward. Receive bytes are read from a right-aligned word, so the final byte of a word comes from the least significant lane. When no transmit source is present, the block writes all-zero words. When no receive destination is present, popped words are dropped. In both cases the byte count still advances by one word size per word.

Top module: `fifo_word_adapter`

## Requirements
- R1: The word size is latched at start from bits_per_word (legal range 4 to 32): 1 byte for 4..8, 2 bytes for 9..16, and 4 bytes for 17..32.
- R2: Transmit byte i of a word (i = 0 first) is placed at bits [31-8i : 24-8i] of out_word. This holds for every word size. Byte lanes that are not used are zero.
- R3: When fewer bytes remain than the word size, the final transmit word is pushed holding only those bytes, with every other lane zero.
- R4: out_push stays low while out_full is high. A finished word is held unchanged on out_word until it is pushed.
- R5: Receive byte i of a popped word is taken from bits [8(w-i-1)+7 : 8(w-i-1)], where w is the word size. Bytes appear on rx_byte in order, and each is held while rx_byte_valid is high and rx_byte_ready is low.
- R6: in_pop is asserted only while in_not_empty is high. Nothing is popped or emitted while the input FIFO is empty.
- R7: With rx_dst_present low at start, each popped word is dropped. rx_byte_valid stays low, and the receive count advances by the word size (capped at the length).
- R8: With tx_src_present low at start, tx_byte_ready stays low and all-zero words are pushed, one for each word size of length.
- R9: After reset, out_push, in_pop, tx_byte_ready, rx_byte_valid and done are all low. A start pulse clears both byte counters and any partly filled transmit word, and loads the new length and word size.
- R10: done is high for exactly one cycle: the cycle after the clock edge at which the receive count reaches the length. It fires once per transfer.
- R11: A transfer of L bytes with word size w pushes exactly ceil(L/w) words and pops exactly ceil(L/w) words. No further bytes are accepted after L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads the configuration and clears the counters |
| xfer_len | input | LEN_W | Transfer length in bytes |
| bits_per_word | input | 6 | Configured bits per word, 4 to 32 |
| tx_src_present | input | 1 | A transmit byte source exists |
| rx_dst_present | input | 1 | A receive byte destination exists |
| tx_byte | input | 8 | Transmit byte |
| tx_byte_valid | input | 1 | Transmit byte offered |
| tx_byte_ready | output | 1 | Transmit byte accepted on this edge if valid |
| out_full | input | 1 | Output FIFO full |
| out_push | output | 1 | Write out_word into the output FIFO |
| out_word | output | 32 | Packed transmit word |
| in_not_empty | input | 1 | Input FIFO holds a word |
| in_pop | output | 1 | Take in_word from the input FIFO |
| in_word | input | 32 | Head word of the input FIFO |
| rx_byte | output | 8 | Received byte |
| rx_byte_valid | output | 1 | rx_byte holds a byte |
| rx_byte_ready | input | 1 | Consumer takes rx_byte on this edge |
| done | output | 1 | One-cycle pulse when the receive count reaches the length |

## Verification
A finished transmit word shows on out_push in the cycle after the edge that takes its last byte, unless out_full is high. The first byte of a popped word is valid in the cycle after the pop edge. done follows the final receive edge by exactly one cycle. The bench records every handshake in a posedge-driven FIFO and consumer model that stamps each event with a cycle counter, and it reads the results at falling edges. The done timing is checked as a difference of one between the stamp of the last receive handshake and the stamp of done. The stall and empty-FIFO checks are read only after enough cycles have passed for a faulty design to have pushed or popped a word.

// File: rtl/fwa_pkg.sv
package fwa_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned BPW_W  = 6;

  typedef logic [2:0] wsz_t;

  // Bytes per FIFO word for a given bits-per-word setting.
  function automatic wsz_t bpw_to_bytes(input logic [BPW_W-1:0] bpw);
    if (bpw <= BPW_W'(8))       return 3'd1;
    else if (bpw <= BPW_W'(16)) return 3'd2;
    else                        return 3'd4;
  endfunction
endpackage

// File: rtl/fwa_tx_pack.sv
module fwa_tx_pack
  import fwa_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  wsz_t              wsize,
  input  logic              has_src,
  input  logic [7:0]        byte_in,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic              fifo_full,
  output logic              fifo_push,
  output logic [WORD_W-1:0] fifo_wdata
);
  logic [LEN_W-1:0]  cnt_q;
  logic [1:0]        lane_q;
  logic              pend_q;
  logic [WORD_W-1:0] word_q;

  logic [LEN_W-1:0] rem;
  logic             more, take, fill, last_lane;

  assign rem        = len - cnt_q;
  assign more       = (cnt_q != len);
  assign byte_ready = has_src && more && !pend_q;
  assign take       = byte_valid && byte_ready;
  assign fill       = !has_src && more && !pend_q;
  assign last_lane  = (({1'b0, lane_q} + 3'd1) == wsize) || (rem == LEN_W'(1));
  assign fifo_push  = pend_q && !fifo_full;
  assign fifo_wdata = word_q;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt_q  <= '0;
      lane_q <= '0;
      pend_q <= 1'b0;
      word_q <= '0;
    end else if (fifo_push) begin
      pend_q <= 1'b0;
      lane_q <= '0;
      word_q <= '0;
    end else if (take) begin
      word_q[{2'd3 - lane_q, 3'b000} +: 8] <= byte_in;
      cnt_q <= cnt_q + LEN_W'(1);
      if (last_lane) pend_q <= 1'b1;
      else           lane_q <= lane_q + 2'd1;
    end else if (fill) begin
      pend_q <= 1'b1;
      word_q <= '0;
      cnt_q  <= (rem < LEN_W'(wsize)) ? len : cnt_q + LEN_W'(wsize);
    end
  end

  a_r4_hold_while_full: assert property (@(posedge clk) disable iff (rst)
    (pend_q && fifo_full && !start) |=> (pend_q && $stable(word_q)));
  a_r11_tx_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= len);
  a_r8_no_src_no_ready: assert property (@(posedge clk) disable iff (rst)
    !has_src |-> !byte_ready);
endmodule

// File: rtl/fwa_rx_unpack.sv
module fwa_rx_unpack
  import fwa_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  wsz_t              wsize,
  input  logic              has_dst,
  input  logic              fifo_not_empty,
  output logic              fifo_pop,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic [7:0]        byte_out,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [LEN_W-1:0]  cnt_next
);
  logic [LEN_W-1:0]  cnt_q;
  logic [1:0]        lane_q;
  wsz_t              nb_q;
  logic              hold_q;
  logic [WORD_W-1:0] word_q;

  logic [LEN_W-1:0] rem;
  logic             more, emit;
  wsz_t             take_n;
  logic [2:0]       sel;

  assign rem        = len - cnt_q;
  assign more       = (cnt_q != len);
  assign take_n     = (rem < LEN_W'(wsize)) ? rem[2:0] : wsize;
  assign fifo_pop   = more && !hold_q && fifo_not_empty;
  assign byte_valid = hold_q;
  assign emit       = hold_q && byte_ready;
  assign sel        = wsize - 3'd1 - {1'b0, lane_q};
  assign byte_out   = word_q[{sel[1:0], 3'b000} +: 8];

  always_comb begin
    cnt_next = cnt_q;
    if (fifo_pop && !has_dst) cnt_next = cnt_q + LEN_W'(take_n);
    else if (emit)            cnt_next = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt_q  <= '0;
      lane_q <= '0;
      nb_q   <= '0;
      hold_q <= 1'b0;
      word_q <= '0;
    end else begin
      cnt_q <= cnt_next;
      if (fifo_pop && has_dst) begin
        word_q <= fifo_rdata;
        hold_q <= 1'b1;
        lane_q <= '0;
        nb_q   <= take_n;
      end else if (emit) begin
        if (({1'b0, lane_q} + 3'd1) == nb_q) hold_q <= 1'b0;
        else                                 lane_q <= lane_q + 2'd1;
      end
    end
  end

  a_r6_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> fifo_not_empty);
  a_r5_byte_held: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_ready && !start) |=> (byte_valid && $stable(byte_out)));
  a_r7_silent_drop: assert property (@(posedge clk) disable iff (rst)
    !has_dst |-> !byte_valid);
  a_r11_rx_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= len);
endmodule

// File: rtl/fwa_done_track.sv
module fwa_done_track #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] cnt_next,
  output logic             done
);
  logic armed_q, reach;

  assign reach = armed_q && (cnt_next == len);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      armed_q <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= reach;
      if (reach) armed_q <= 1'b0;
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/fifo_word_adapter.sv
module fifo_word_adapter
  import fwa_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [BPW_W-1:0]  bits_per_word,
  input  logic              tx_src_present,
  input  logic              rx_dst_present,
  input  logic [7:0]        tx_byte,
  input  logic              tx_byte_valid,
  output logic              tx_byte_ready,
  input  logic              out_full,
  output logic              out_push,
  output logic [WORD_W-1:0] out_word,
  input  logic              in_not_empty,
  output logic              in_pop,
  input  logic [WORD_W-1:0] in_word,
  output logic [7:0]        rx_byte,
  output logic              rx_byte_valid,
  input  logic              rx_byte_ready,
  output logic              done
);
  logic [LEN_W-1:0] len_q;
  wsz_t             wsz_q;
  logic             txp_q, rxp_q;
  logic [LEN_W-1:0] rx_cnt_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      wsz_q <= 3'd1;
      txp_q <= 1'b0;
      rxp_q <= 1'b0;
    end else if (start) begin
      len_q <= xfer_len;
      wsz_q <= bpw_to_bytes(bits_per_word);
      txp_q <= tx_src_present;
      rxp_q <= rx_dst_present;
    end
  end

  fwa_tx_pack #(.LEN_W(LEN_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .len        (len_q),
    .wsize      (wsz_q),
    .has_src    (txp_q),
    .byte_in    (tx_byte),
    .byte_valid (tx_byte_valid),
    .byte_ready (tx_byte_ready),
    .fifo_full  (out_full),
    .fifo_push  (out_push),
    .fifo_wdata (out_word)
  );

  fwa_rx_unpack #(.LEN_W(LEN_W)) u_rx (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .len            (len_q),
    .wsize          (wsz_q),
    .has_dst        (rxp_q),
    .fifo_not_empty (in_not_empty),
    .fifo_pop       (in_pop),
    .fifo_rdata     (in_word),
    .byte_out       (rx_byte),
    .byte_valid     (rx_byte_valid),
    .byte_ready     (rx_byte_ready),
    .cnt_next       (rx_cnt_next)
  );

  fwa_done_track #(.LEN_W(LEN_W)) u_done (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .len      (len_q),
    .cnt_next (rx_cnt_next),
    .done     (done)
  );

  a_r1_size_legal: assert property (@(posedge clk) disable iff (rst)
    (wsz_q == 3'd1) || (wsz_q == 3'd2) || (wsz_q == 3'd4));
endmodule

// File: tb/sim_fifo_word_adapter.sv
module sim_fifo_word_adapter;
  localparam int CLK_P = 10;
  localparam int LEN_W = 16;
  localparam int NV    = 10;
  // {bpw[5:0], len[7:0], tx present, rx present, stall}
  localparam logic [16:0] VEC [NV] = '{
    {6'd8,  8'd5, 1'b1, 1'b1, 1'b0},
    {6'd9,  8'd2, 1'b1, 1'b1, 1'b0},
    {6'd16, 8'd6, 1'b1, 1'b1, 1'b1},
    {6'd17, 8'd4, 1'b1, 1'b1, 1'b0},
    {6'd12, 8'd5, 1'b1, 1'b1, 1'b0},
    {6'd24, 8'd7, 1'b1, 1'b1, 1'b1},
    {6'd4,  8'd3, 1'b1, 1'b1, 1'b0},
    {6'd32, 8'd6, 1'b0, 1'b0, 1'b0},
    {6'd16, 8'd5, 1'b0, 1'b1, 1'b0},
    {6'd32, 8'd8, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [LEN_W-1:0] xfer_len = '0;
  logic [5:0] bpw = 6'd8;
  logic txp = 1'b0, rxp = 1'b0;
  logic [7:0] tx_byte = '0;
  logic tx_valid = 1'b0, tx_ready;
  logic out_full = 1'b0, out_push;
  logic [31:0] out_word;
  logic in_not_empty, in_pop;
  logic [31:0] in_word;
  logic [7:0] rx_byte;
  logic rx_valid, rx_ready = 1'b1, rdy_slow = 1'b0;
  logic done;

  int checks = 0, fails = 0;

  // FIFO and consumer models
  logic [31:0] in_mem [32];
  logic [31:0] omem [32];
  logic [7:0]  rmem [32];
  int in_cnt = 0, in_rd = 0, ow = 0, rb = 0, dn = 0;
  int cyc = 0, last_rx_cyc = 0, done_cyc = 0;
  logic m_clr = 1'b0;

  assign in_not_empty = (in_rd < in_cnt);
  assign in_word      = in_mem[in_rd[4:0]];

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (m_clr) begin
      in_rd <= 0; ow <= 0; rb <= 0; dn <= 0;
    end else begin
      if (in_pop) in_rd <= in_rd + 1;
      if (out_push) begin omem[ow[4:0]] <= out_word; ow <= ow + 1; end
      if (rx_valid && rx_ready) begin
        rmem[rb[4:0]] <= rx_byte; rb <= rb + 1; last_rx_cyc <= cyc;
      end
      if (done) begin dn <= dn + 1; done_cyc <= cyc; end
    end
  end

  always @(negedge clk) rx_ready <= rdy_slow ? ~rx_ready : 1'b1;

  fifo_word_adapter #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .xfer_len(xfer_len),
    .bits_per_word(bpw), .tx_src_present(txp), .rx_dst_present(rxp),
    .tx_byte(tx_byte), .tx_byte_valid(tx_valid), .tx_byte_ready(tx_ready),
    .out_full(out_full), .out_push(out_push), .out_word(out_word),
    .in_not_empty(in_not_empty), .in_pop(in_pop), .in_word(in_word),
    .rx_byte(rx_byte), .rx_byte_valid(rx_valid), .rx_byte_ready(rx_ready),
    .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wsz(input logic [5:0] b);
    if (b <= 6'd8) return 1;
    if (b <= 6'd16) return 2;
    return 4;
  endfunction

  function automatic logic [7:0] txd(input int v, input int i);
    return 8'(8'h21 * (v + 1) + i * 7);
  endfunction

  task automatic tx_send(input logic [7:0] b);
    tx_valid = 1'b1; tx_byte = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic begin_xfer(input logic [5:0] b, input int len, input logic tp, input logic rp);
    bpw = b; xfer_len = LEN_W'(len); txp = tp; rxp = rp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic clear_models();
    in_cnt = 0;
    m_clr = 1'b1;
    @(negedge clk);
    m_clr = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 push after reset", {31'd0, out_push}, 32'd0);
    chk("R9 pop after reset", {31'd0, in_pop}, 32'd0);
    chk("R9 tx ready after reset", {31'd0, tx_ready}, 32'd0);
    chk("R9 rx valid after reset", {31'd0, rx_valid}, 32'd0);
    chk("R9 done after reset", {31'd0, done}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [5:0] b;
      int len, w, nw;
      logic tp, rp, st;
      b = VEC[v][16:11]; len = int'(VEC[v][10:3]);
      tp = VEC[v][2]; rp = VEC[v][1]; st = VEC[v][0];
      w = wsz(b); nw = (len + w - 1) / w;
      rdy_slow = v[0];
      clear_models();
      for (int k = 0; k < 32; k++)
        in_mem[k] = 32'h8C4A2E17 + 32'(k) * 32'h01020304 + 32'(v) * 32'h11000000;
      out_full = st;
      begin_xfer(b, len, tp, rp);
      in_cnt = nw;
      fork
        begin
          if (tp) for (int i = 0; i < len; i++) tx_send(txd(v, i));
        end
        begin
          if (st) begin
            repeat (8) @(negedge clk);
            chk("R4 no push while full", 32'(ow), 32'd0);
            out_full = 1'b0;
          end
        end
      join
      for (int t = 0; t < 300; t++) begin
        if (dn >= 1 && ow >= nw) break;
        @(negedge clk);
      end
      repeat (4) @(negedge clk);
      // R11 / R8 word count, R1 word size visible through it
      chk("R11 R1 words pushed", 32'(ow), 32'(nw));
      for (int k = 0; k < nw; k++) begin
        logic [31:0] e;
        e = '0;
        if (tp)
          for (int i = 0; i < w; i++)
            if (k * w + i < len) e[31 - 8*i -: 8] = txd(v, k * w + i);
        chk(tp ? "R2 R3 tx word" : "R8 zero word", omem[k], e);
      end
      chk("R11 words popped", 32'(in_rd), 32'(nw));
      chk("R7 rx bytes emitted", 32'(rb), rp ? 32'(len) : 32'd0);
      if (rp)
        for (int j = 0; j < len; j++) begin
          logic [31:0] wd;
          wd = in_mem[j / w];
          chk("R5 rx byte", {24'd0, rmem[j]}, {24'd0, 8'(wd >> (8 * (w - (j % w) - 1)))});
        end
      chk("R10 done once", 32'(dn), 32'd1);
    end
    rdy_slow = 1'b0;

    // R6 empty input FIFO, then R10 timing
    clear_models();
    begin_xfer(6'd8, 2, 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    chk("R6 no pop while empty", 32'(in_rd), 32'd0);
    chk("R6 no byte while empty", 32'(rb), 32'd0);
    chk("R10 no done early", 32'(dn), 32'd0);
    in_mem[0] = 32'h123456C3; in_mem[1] = 32'hABCDEF5A;
    in_cnt = 2;
    for (int t = 0; t < 100 && dn == 0; t++) @(negedge clk);
    @(negedge clk);
    chk("R5 w1 low byte 0", {24'd0, rmem[0]}, 32'h000000C3);
    chk("R5 w1 low byte 1", {24'd0, rmem[1]}, 32'h0000005A);
    chk("R10 done timing", 32'(done_cyc - last_rx_cyc), 32'd1);
    chk("R10 single pulse", 32'(dn), 32'd1);

    // R9 restart drops a partly filled word
    clear_models();
    begin_xfer(6'd32, 4, 1'b1, 1'b0);
    tx_send(8'h77);
    repeat (2) @(negedge clk);
    begin_xfer(6'd16, 2, 1'b1, 1'b0);
    tx_send(8'hAA);
    tx_send(8'hBB);
    repeat (4) @(negedge clk);
    chk("R9 restart word count", 32'(ow), 32'd1);
    chk("R9 restart word", omem[0], 32'hAABB0000);
    chk("R11 no ready after length", {31'd0, tx_ready}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule